// File: doc/BRIEF.md
# Nibble Processor Core

This block is a small 4-bit processor. It runs one instruction per clock from a 32-line program that is fixed when the block is elaborated. Its data store holds sixteen nibbles. Results do not go to a numbered register. Each instruction steers its result onto one of three visible 4-bit buses: primary, secondary and excess. Any instruction can later copy the contents of a bus back into the data store. Two-operand instructions also load a 3-bit flag bus with the outcome of an unsigned comparison of their operands. Conditional jumps test one chosen bit of that flag bus.

After reset the core waits in the halted state. A one-cycle start pulse sends it to line 0, and it runs until it executes a halt instruction or sees another start. The debug outputs show the program counter, the three buses, the flags and the halted state. The program and the initial data contents are set by parameters.

Top module: `nibble_core`

## Requirements
- R1: Reset sets the program counter to 0, sets halted, clears the three buses and the flags, and loads data nibble i from bits [4i+3:4i] of the data-init parameter.
- R2: A start pulse sets the program counter to 0 and clears halted at the next edge, in place of whatever instruction would run in that cycle, a halt included.
- R3: While running, the core executes one 12-bit word per clock. The opcode is in bits [11:8]. Opcode 0 and the unused opcode F do nothing. The program counter advances by one and wraps from 31 to 0.
- R4: Opcode 1 (read) fetches the nibble at the address in [7:4]. If bit [0] is 0 the nibble goes to the primary bus, and if it is 1 it goes to the secondary bus.
- R5: Opcode 2 (write) stores one source into the nibble at the address in [7:4]. Bits [1:0] pick the source: 00 primary, 01 secondary, 10 excess, 11 the instruction's own bits [3:0].
- R6: Opcodes 3 add, 4 subtract, 6 or, 7 and and 8 xor combine the nibble at [7:4] (first) with the nibble at [3:0] (second). The low 4 bits go to the primary bus and any carry or borrow is dropped. Opcode 9 places the inverse of the nibble at [7:4] on the primary bus.
- R7: Opcode 5 multiplies the two addressed nibbles. The product's bits 3:0 go to the primary bus and bits 7:4 go to the excess bus.
- R8: Opcodes 3 to 8 load the flags with an unsigned comparison of first against second: bit 0 greater, bit 1 less, bit 2 equal. All other opcodes leave the flags unchanged.
- R9: Opcode A loads the program counter with bits [7:3].
- R10: Opcode B jumps to [7:3] when the flag picked by [2:1] is set, and opcode C jumps there when it is clear. Select values 00, 01 and 10 pick flag bits 0, 1 and 2. Select 11 always reads as clear.
- R11: Opcode D exchanges the primary and secondary buses in one cycle.
- R12: Opcode E sets halted. While halted and without a start pulse, the program counter, buses, flags and data store do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; restarts at line 0 |
| halted_o | output | 1 | Core is halted |
| pc_o | output | 5 | Program counter |
| pbus_o | output | 4 | Primary bus |
| sbus_o | output | 4 | Secondary bus |
| ebus_o | output | 4 | Excess bus |
| flags_o | output | 3 | Comparison flags {equal, less, greater} |

## Verification
A start pulse can arrive in the same cycle as the execution of a halt instruction. The halt would set halted and freeze the counter, while the start clears halted and returns the counter to line 0. The bench counts the cycles of a program whose second pass ends on a halt and raises start on exactly the edge where that halt runs. The expected result is a running core at line 0 that then repeats the pass. A later pass reaches the same halt with no start pulse, and there the core must stop and hold all of its state.

// File: rtl/nibble_core.sv
module nibble_core #(
  parameter logic [383:0] PROGRAM   = '0,
  parameter logic [63:0]  DATA_INIT = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       halted_o,
  output logic [4:0] pc_o,
  output logic [3:0] pbus_o,
  output logic [3:0] sbus_o,
  output logic [3:0] ebus_o,
  output logic [2:0] flags_o
);
  localparam int IW    = 12;
  localparam int LINES = $bits(PROGRAM) / IW;
  localparam int WORDS = $bits(DATA_INIT) / 4;

  logic [3:0]    mem [WORDS];
  logic [4:0]    pc;
  logic [3:0]    pbus, sbus, ebus;
  logic [2:0]    flags;
  logic          halted;
  logic [IW-1:0] instr;
  logic [3:0]    op, opa, opb, wdata;
  logic [7:0]    prod;
  logic          two_op, cond;

  assign instr  = PROGRAM[int'(pc) * IW +: IW];
  assign op     = instr[11:8];
  assign opa    = mem[instr[7:4]];
  assign opb    = mem[instr[3:0]];
  assign prod   = opa * opb;
  assign two_op = (op >= 4'h3) && (op <= 4'h8);

  always_comb begin
    case (instr[2:1])
      2'b00:   cond = flags[0];
      2'b01:   cond = flags[1];
      2'b10:   cond = flags[2];
      default: cond = 1'b0;
    endcase
    case (instr[1:0])
      2'b00:   wdata = pbus;
      2'b01:   wdata = sbus;
      2'b10:   wdata = ebus;
      default: wdata = instr[3:0];
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pc     <= '0;
      halted <= 1'b1;
      pbus   <= '0;
      sbus   <= '0;
      ebus   <= '0;
      flags  <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= DATA_INIT[i*4 +: 4];
    end else if (start_i) begin
      pc     <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      pc <= pc + 5'd1;
      if (two_op) flags <= {opa == opb, opa < opb, opa > opb};
      case (op)
        4'h1: if (instr[0]) sbus <= opa; else pbus <= opa;
        4'h2: mem[instr[7:4]] <= wdata;
        4'h3: pbus <= opa + opb;
        4'h4: pbus <= opa - opb;
        4'h5: begin
          pbus <= prod[3:0];
          ebus <= prod[7:4];
        end
        4'h6: pbus <= opa | opb;
        4'h7: pbus <= opa & opb;
        4'h8: pbus <= opa ^ opb;
        4'h9: pbus <= ~opa;
        4'hA: pc <= instr[7:3];
        4'hB: if (cond) pc <= instr[7:3];
        4'hC: if (!cond) pc <= instr[7:3];
        4'hD: begin
          pbus <= sbus;
          sbus <= pbus;
        end
        4'hE: begin
          pc     <= pc;
          halted <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign halted_o = halted;
  assign pc_o     = pc;
  assign pbus_o   = pbus;
  assign sbus_o   = sbus;
  assign ebus_o   = ebus;
  assign flags_o  = flags;
endmodule

// File: rtl/nibble_core_chk.sv
module nibble_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        halted_o,
  input logic [4:0]  pc_o,
  input logic [3:0]  pbus_o,
  input logic [3:0]  sbus_o,
  input logic [2:0]  flags_o,
  input logic [11:0] instr
);
  logic run, seq;
  assign run = !halted_o && !start_i;
  assign seq = !(instr[11:8] inside {4'hA, 4'hB, 4'hC, 4'hE});

  p_start_restarts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (pc_o == 5'd0) && !halted_o);

  p_pc_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && seq) |=> pc_o == $past(pc_o) + 5'd1);

  p_flags_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flags_o));

  p_jump_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && instr[11:8] == 4'hA) |=> pc_o == $past(instr[7:3]));

  p_swap_buses_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && instr[11:8] == 4'hD) |=> (pbus_o == $past(sbus_o)) && (sbus_o == $past(pbus_o)));

  p_halt_freezes_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !start_i) |=> halted_o && $stable(pc_o) && $stable(pbus_o) && $stable(flags_o));
endmodule

bind nibble_core nibble_core_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .halted_o(halted_o),
  .pc_o(pc_o), .pbus_o(pbus_o), .sbus_o(sbus_o), .flags_o(flags_o), .instr(instr)
);

// File: tb/nibble_core_tb_top.sv
module nibble_core_tb_top;
  localparam int CLK_NS = 10;

  function automatic logic [383:0] build_prog();
    logic [383:0] p = '0;
    p[0*12  +: 12] = 12'h301;
    p[1*12  +: 12] = 12'h523;
    p[2*12  +: 12] = 12'h141;
    p[3*12  +: 12] = 12'hD00;
    p[4*12  +: 12] = 12'h410;
    p[5*12  +: 12] = 12'h252;
    p[6*12  +: 12] = 12'h150;
    p[7*12  +: 12] = 12'h267;
    p[8*12  +: 12] = 12'h662;
    p[9*12  +: 12] = 12'h726;
    p[10*12 +: 12] = 12'h920;
    p[11*12 +: 12] = 12'h874;
    p[12*12 +: 12] = 12'hB72;
    p[13*12 +: 12] = 12'hE00;
    p[14*12 +: 12] = 12'hC02;
    p[15*12 +: 12] = 12'hB06;
    p[16*12 +: 12] = 12'hC96;
    p[17*12 +: 12] = 12'hE00;
    p[18*12 +: 12] = 12'h333;
    p[19*12 +: 12] = 12'h270;
    p[20*12 +: 12] = 12'hAF0;
    p[31*12 +: 12] = 12'hF00;
    return p;
  endfunction

  localparam logic [383:0] PROG = build_prog();
  localparam logic [63:0]  DINIT = 64'h0000_0000_0009_FC35;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic halted;
  logic [4:0] pc;
  logic [3:0] pbus, sbus, ebus;
  logic [2:0] flags;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] pc;
    logic [3:0] p, s, e;
    logic [2:0] f;
    logic       h;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_NS/2) clk = ~clk;

  nibble_core #(.PROGRAM(PROG), .DATA_INIT(DINIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .halted_o(halted),
    .pc_o(pc), .pbus_o(pbus), .sbus_o(sbus), .ebus_o(ebus), .flags_o(flags)
  );

  task automatic compare(exp_t x);
    checks++;
    if (pc !== x.pc || pbus !== x.p || sbus !== x.s || ebus !== x.e ||
        flags !== x.f || halted !== x.h) begin
      errors++;
      $display("FAIL %s: got pc=%0d p=%h s=%h e=%h f=%b h=%b, expected pc=%0d p=%h s=%h e=%h f=%b h=%b",
               x.tag, pc, pbus, sbus, ebus, flags, halted, x.pc, x.p, x.s, x.e, x.f, x.h);
    end
  endtask

  always @(negedge clk) if (q.size() > 0) compare(q.pop_front());

  task automatic exp(input logic [4:0] epc, input logic [3:0] ep, es, ee,
                     input logic [2:0] ef, input logic eh, input bit pulse, input string tag);
    exp_t x;
    if (pulse) begin
      @(negedge clk);
      start = 1'b1;
    end
    @(posedge clk);
    #1;
    start = 1'b0;
    x.pc = epc; x.p = ep; x.s = es; x.e = ee; x.f = ef; x.h = eh; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic second_pass(input bit start_on_halt);
    exp(5'd1,  4'h8, 4'h4, 4'hB, 3'b001, 1'b0, 1'b0, "R6 add again, R8 greater");
    exp(5'd2,  4'h4, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R7 mul");
    exp(5'd3,  4'h4, 4'h9, 4'hB, 3'b010, 1'b0, 1'b0, "R4 read to secondary");
    exp(5'd4,  4'h9, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R11 swap");
    exp(5'd5,  4'hE, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R6 sub");
    exp(5'd6,  4'hE, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R5 write excess");
    exp(5'd7,  4'hB, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R4 read back");
    exp(5'd8,  4'hB, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R5 write imm");
    exp(5'd9,  4'hF, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R6 or");
    exp(5'd10, 4'h4, 4'h4, 4'hB, 3'b001, 1'b0, 1'b0, "R6 and");
    exp(5'd11, 4'h3, 4'h4, 4'hB, 3'b001, 1'b0, 1'b0, "R6 not, R8 flags kept");
    exp(5'd12, 4'h7, 4'h4, 4'hB, 3'b001, 1'b0, 1'b0, "R5 stored primary seen by xor");
    exp(5'd13, 4'h7, 4'h4, 4'hB, 3'b001, 1'b0, 1'b0, "R10 jmpif less not taken");
    if (start_on_halt)
      exp(5'd0, 4'h7, 4'h4, 4'hB, 3'b001, 1'b0, 1'b1, "R2 start beats halt");
    else
      exp(5'd13, 4'h7, 4'h4, 4'hB, 3'b001, 1'b1, 1'b0, "R12 halt");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    begin
      exp_t r;
      r.pc = 5'd0; r.p = 4'h0; r.s = 4'h0; r.e = 4'h0; r.f = 3'b000; r.h = 1'b1; r.tag = "R1 reset state";
      compare(r);
    end
    exp(5'd0, 4'h0, 4'h0, 4'h0, 3'b000, 1'b1, 1'b0, "R1 idle halted after reset");
    exp(5'd0, 4'h0, 4'h0, 4'h0, 3'b000, 1'b0, 1'b1, "R2 start");
    exp(5'd1,  4'h8, 4'h0, 4'h0, 3'b001, 1'b0, 1'b0, "R6 add, R1 init data, R8 greater");
    exp(5'd2,  4'h4, 4'h0, 4'hB, 3'b010, 1'b0, 1'b0, "R7 mul low/high, R8 less");
    exp(5'd3,  4'h4, 4'h9, 4'hB, 3'b010, 1'b0, 1'b0, "R4 read to secondary");
    exp(5'd4,  4'h9, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R11 swap");
    exp(5'd5,  4'hE, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R6 sub borrow dropped");
    exp(5'd6,  4'hE, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R5 write from excess");
    exp(5'd7,  4'hB, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R4 read to primary, R5 excess stored");
    exp(5'd8,  4'hB, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R5 write immediate");
    exp(5'd9,  4'hF, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R6 or, R5 immediate stored");
    exp(5'd10, 4'h4, 4'h4, 4'hB, 3'b001, 1'b0, 1'b0, "R6 and");
    exp(5'd11, 4'h3, 4'h4, 4'hB, 3'b001, 1'b0, 1'b0, "R6 not, R8 flags kept");
    exp(5'd12, 4'h9, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R6 xor");
    exp(5'd14, 4'h9, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R10 jmpif less taken");
    exp(5'd15, 4'h9, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R10 jmpifnot less not taken");
    exp(5'd16, 4'h9, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R10 select 11 jmpif never");
    exp(5'd18, 4'h9, 4'h4, 4'hB, 3'b010, 1'b0, 1'b0, "R10 select 11 jmpifnot always");
    exp(5'd19, 4'hE, 4'h4, 4'hB, 3'b100, 1'b0, 1'b0, "R6 add carry dropped, R8 equal");
    exp(5'd20, 4'hE, 4'h4, 4'hB, 3'b100, 1'b0, 1'b0, "R5 write primary");
    exp(5'd30, 4'hE, 4'h4, 4'hB, 3'b100, 1'b0, 1'b0, "R9 jmp");
    exp(5'd31, 4'hE, 4'h4, 4'hB, 3'b100, 1'b0, 1'b0, "R3 nop");
    exp(5'd0,  4'hE, 4'h4, 4'hB, 3'b100, 1'b0, 1'b0, "R3 opcode F nop and wrap");
    second_pass(1'b1);
    second_pass(1'b0);
    for (int k = 0; k < 4; k++)
      exp(5'd13, 4'h7, 4'h4, 4'hB, 3'b001, 1'b1, 1'b0, "R12 halt holds");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_NS * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule